// File: doc/BRIEF.md
# Session-Level Test Access Controller

This block is the chip-level test controller for a set of wrapped cores. A standard four-wire test access port (test clock, mode select, serial data in and out, plus an active-low test reset) walks a sixteen-state controller. The controller's states are decoded into wrapper control strobes that go to every core in the active test session at once. The wrapper boundary cells load and unload test data while the port rests in Pause-DR. Each vector is then applied by a fixed five-state loop. That loop forces the core inputs, toggles the functional clock for three cycles, measures the core outputs, and pulses the scan clocks before it returns to Pause-DR.

An instruction register chooses what the serial data path does. One instruction enables the wrapper strobes. Another exposes a session-select register that drives the select lines of the multiplexer-based test access bus. Any other code selects a one-bit bypass. Scan-clock groups can be marked as staggered. A staggered group is pulsed in Shift-DR rather than in Exit1-DR, so cores whose scan enable stays high during the capture pulse can still share the single test scan enable. A staggered group costs one extra cycle per vector.

Top module: `tap_session_ctrl`

## Requirements
- R1: While trst_n is low, the controller is held in Test-Logic-Reset, the instruction is bypass, and sess_sel, every wrapper strobe, scan_clk_en, tse, func_clk_en, test_mode and tdo are 0. sess_sel clears at once, without waiting for a clock edge.
- R2: Five consecutive TCK edges with tms high bring the controller to Test-Logic-Reset from any state. On the next edge, sess_sel clears to 0 and the instruction reverts to bypass. Four such edges do not clear sess_sel.
- R3: When the wrapper-test instruction (code 4'b0011) is loaded, wr_shift and tse are high in Pause-DR and low in every other state.
- R4: When the wrapper-test instruction is loaded, wr_update is high in Exit2-DR only.
- R5: When the wrapper-test instruction is loaded, wr_capture is high in Capture-DR only.
- R6: When the wrapper-test instruction is loaded, func_clk_en is high in Exit2-DR, in Update-DR, and in Select-DR-Scan when that state was entered from Update-DR. This gives at most three consecutive cycles. func_clk_en stays low in Select-DR-Scan when that state is entered from Run-Test/Idle.
- R7: When the wrapper-test instruction is loaded, scan_clk_en[g] is high in Exit1-DR for a group whose STAGGER_MASK bit is 0, and in every Shift-DR cycle for a group whose bit is 1. With the defaults, group 0 is plain and group 1 is staggered.
- R8: The session instruction (code 4'b0010) selects the session register as the data register. Capture-DR loads the current sess_sel into it. Shift-DR moves tdi in at the MSB and presents the LSB on tdo. sess_sel takes the shifted value on the edge that leaves Update-DR and keeps its old value before that edge.
- R9: Any code other than 4'b0010 and 4'b0011 selects a one-bit bypass register. The bypass captures 0, and in Shift-DR tdo shows the tdi value from one cycle earlier.
- R10: test_mode is 0 while trst_n is low and becomes 1 on the first TCK edge after release. It then stays 1 until the next reset.
- R11: Capture-IR loads the pattern 4'b0001, and it leaves on tdo LSB first during Shift-IR.
- R12: Under any instruction other than wrapper-test, wr_shift, wr_update, wr_capture, tse, func_clk_en and scan_clk_en all stay 0, including in Pause-DR, Capture-DR and Exit1-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset; low means functional mode |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out; IR LSB in Shift-IR, selected DR LSB in Shift-DR, else 0 |
| wr_shift | output | 1 | Broadcast wrapper shift enable (load/unload) |
| wr_update | output | 1 | Broadcast wrapper update strobe (force inputs) |
| wr_capture | output | 1 | Broadcast wrapper capture strobe (measure outputs) |
| scan_clk_en | output | N_GRP | Per-group scan clock pulse enable |
| tse | output | 1 | Shared test scan enable for all cores |
| func_clk_en | output | 1 | Functional clock gate enable during the force step |
| sess_sel | output | SEL_W | Session select code driving the TAM multiplexers |
| test_mode | output | 1 | Chip in test mode; test IOs multiplexed onto pins |

## Verification
The bench builds the block with its defaults: four-bit instructions, a three-bit session code, and two scan-clock groups with only group 1 staggered. This puts a plain group and a staggered group side by side in one vector loop. A table walks three consecutive vectors, one of them taking the extra Shift-DR cycle, followed by an Update-DR exit to Run-Test/Idle and a re-entry from idle. This shows that the functional clock window depends on the path taken into Select-DR-Scan. Directed sequences cover session register load and readback, bypass delay, the IR capture pattern, suppression of the strobes under other instructions, the four-versus-five tms-high reset boundary, and an asynchronous reset in mid-run.

// File: rtl/tap_session_pkg.sv
package tap_session_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'h0,
        ST_IDLE     = 4'h1,
        ST_DR_SEL   = 4'h2,
        ST_DR_CAP   = 4'h3,
        ST_DR_SHIFT = 4'h4,
        ST_DR_EXIT1 = 4'h5,
        ST_DR_PAUSE = 4'h6,
        ST_DR_EXIT2 = 4'h7,
        ST_DR_UPD   = 4'h8,
        ST_IR_SEL   = 4'h9,
        ST_IR_CAP   = 4'hA,
        ST_IR_SHIFT = 4'hB,
        ST_IR_EXIT1 = 4'hC,
        ST_IR_PAUSE = 4'hD,
        ST_IR_EXIT2 = 4'hE,
        ST_IR_UPD   = 4'hF
    } tap_state_e;

    function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
        tap_state_e nxt;
        case (cur)
            ST_RESET:    nxt = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = m ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nxt = m ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nxt = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: nxt = m ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: nxt = m ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = m ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nxt = m ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: nxt = m ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: nxt = m ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = m ? ST_DR_SEL   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tap_state_fsm.sv
module tap_state_fsm
    import tap_session_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output logic       from_upd_q
);

    typedef struct packed {
        tap_state_e st;
        logic       from_upd;
    } fsm_t;

    fsm_t cur_q, cur_d;

    always_comb begin
        cur_d          = cur_q;
        cur_d.st       = tap_next(cur_q.st, tms);
        cur_d.from_upd = (cur_q.st == ST_DR_UPD);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            cur_q <= '{st: ST_RESET, from_upd: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign state_q    = cur_q.st;
    assign from_upd_q = cur_q.from_upd;

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
    import tap_session_pkg::*;
#(
    parameter int IR_W = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] instr_q,
    output logic            ir_tdo
);

    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);
    localparam logic [IR_W-1:0] INS_BYP = '1;

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] ins;
    } ir_t;

    ir_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET:    r_d.ins = INS_BYP;
            ST_IR_CAP:   r_d.sh  = CAP_PAT;
            ST_IR_SHIFT: r_d.sh  = {tdi, r_q.sh[IR_W-1:1]};
            ST_IR_UPD:   r_d.ins = r_q.sh;
            default:     r_d     = r_q;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q <= '{sh: CAP_PAT, ins: INS_BYP};
        end else begin
            r_q <= r_d;
        end
    end

    assign instr_q = r_q.ins;
    assign ir_tdo  = r_q.sh[0];

endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
    import tap_session_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state,
    input  logic             tdi,
    input  logic             use_session,
    output logic [SEL_W-1:0] sess_q,
    output logic             dr_tdo
);

    typedef struct packed {
        logic [SEL_W-1:0] sh;
        logic [SEL_W-1:0] sel;
        logic             byp;
    } dr_t;

    dr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET: r_d.sel = '0;
            ST_DR_CAP: begin
                r_d.byp = 1'b0;
                if (use_session) begin
                    r_d.sh = r_q.sel;
                end
            end
            ST_DR_SHIFT: begin
                if (use_session) begin
                    r_d.sh = {tdi, r_q.sh[SEL_W-1:1]};
                end else begin
                    r_d.byp = tdi;
                end
            end
            ST_DR_UPD: begin
                if (use_session) begin
                    r_d.sel = r_q.sh;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q <= '{sh: '0, sel: '0, byp: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sess_q = r_q.sel;
    assign dr_tdo = use_session ? r_q.sh[0] : r_q.byp;

endmodule

// File: rtl/tap_session_ctrl.sv
module tap_session_ctrl
    import tap_session_pkg::*;
#(
    parameter int               IR_W         = 4,
    parameter int               SEL_W        = 3,
    parameter int               N_GRP        = 2,
    parameter logic [N_GRP-1:0] STAGGER_MASK = 2'b10
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             wr_shift,
    output logic             wr_update,
    output logic             wr_capture,
    output logic [N_GRP-1:0] scan_clk_en,
    output logic             tse,
    output logic             func_clk_en,
    output logic [SEL_W-1:0] sess_sel,
    output logic             test_mode
);

    localparam logic [IR_W-1:0] INS_SESSION = IR_W'(2);
    localparam logic [IR_W-1:0] INS_WRAP    = IR_W'(3);

    tap_state_e      state;
    logic            from_upd;
    logic [IR_W-1:0] instr;
    logic            ir_tdo;
    logic            dr_tdo;
    logic            wrap_on;
    logic            mode_q, mode_d;

    tap_state_fsm u_fsm (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .state_q   (state),
        .from_upd_q(from_upd)
    );

    tap_instr_reg #(.IR_W(IR_W)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .instr_q(instr),
        .ir_tdo (ir_tdo)
    );

    tap_data_regs #(.SEL_W(SEL_W)) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .state      (state),
        .tdi        (tdi),
        .use_session(instr == INS_SESSION),
        .sess_q     (sess_sel),
        .dr_tdo     (dr_tdo)
    );

    assign wrap_on = (instr == INS_WRAP);

    always_comb begin
        wr_shift    = wrap_on && (state == ST_DR_PAUSE);
        tse         = wrap_on && (state == ST_DR_PAUSE);
        wr_update   = wrap_on && (state == ST_DR_EXIT2);
        wr_capture  = wrap_on && (state == ST_DR_CAP);
        func_clk_en = wrap_on && ((state == ST_DR_EXIT2) || (state == ST_DR_UPD) ||
                                  ((state == ST_DR_SEL) && from_upd));
        case (state)
            ST_IR_SHIFT: tdo = ir_tdo;
            ST_DR_SHIFT: tdo = dr_tdo;
            default:     tdo = 1'b0;
        endcase
        mode_d = 1'b1;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        if (STAGGER_MASK[g]) begin : g_stag
            assign scan_clk_en[g] = wrap_on && (state == ST_DR_SHIFT);
        end else begin : g_plain
            assign scan_clk_en[g] = wrap_on && (state == ST_DR_EXIT1);
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign test_mode = mode_q;

endmodule

// File: rtl/tap_session_ctrl_chk.sv
module tap_session_ctrl_chk #(
    parameter int               N_GRP        = 2,
    parameter logic [N_GRP-1:0] STAGGER_MASK = 2'b10
) (
    input logic             tck,
    input logic             trst_n,
    input logic             wr_shift,
    input logic             wr_update,
    input logic             wr_capture,
    input logic             func_clk_en,
    input logic [N_GRP-1:0] scan_clk_en,
    input logic             test_mode
);

    // R4: Exit2-DR is reached only from Pause-DR
    a_r4_update_after_shift: assert property (@(posedge tck) disable iff (!trst_n)
        wr_update |-> $past(wr_shift));

    // R5: Capture-DR lasts a single cycle
    a_r5_capture_single: assert property (@(posedge tck) disable iff (!trst_n)
        wr_capture |=> !wr_capture);

    // R6: force window never longer than three cycles
    a_r6_func_max3: assert property (@(posedge tck) disable iff (!trst_n)
        (func_clk_en && $past(func_clk_en) && $past(func_clk_en, 2)) |=> !func_clk_en);

    // R3 R4 R5: strobes are mutually exclusive
    a_r3_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        $countones({wr_shift, wr_update, wr_capture}) <= 1);

    // R10: test mode holds until reset
    a_r10_mode_sticky: assert property (@(posedge tck) disable iff (!trst_n)
        test_mode |=> test_mode);

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        if (!STAGGER_MASK[g]) begin : g_plain
            // R7: plain group pulses for one Exit1-DR cycle
            a_r7_plain_pulse: assert property (@(posedge tck) disable iff (!trst_n)
                scan_clk_en[g] |=> !scan_clk_en[g]);
        end
    end

endmodule

bind tap_session_ctrl tap_session_ctrl_chk #(
    .N_GRP       (N_GRP),
    .STAGGER_MASK(STAGGER_MASK)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .wr_shift   (wr_shift),
    .wr_update  (wr_update),
    .wr_capture (wr_capture),
    .func_clk_en(func_clk_en),
    .scan_clk_en(scan_clk_en),
    .test_mode  (test_mode)
);

// File: tb/tb_tap_session_ctrl.sv
module tb_tap_session_ctrl;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo;
    logic       wr_shift, wr_update, wr_capture, tse, func_clk_en, test_mode;
    logic [1:0] scan_clk_en;
    logic [2:0] sess_sel;

    int checks = 0;
    int errors = 0;

    tap_session_ctrl dut (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .wr_shift   (wr_shift),
        .wr_update  (wr_update),
        .wr_capture (wr_capture),
        .scan_clk_en(scan_clk_en),
        .tse        (tse),
        .func_clk_en(func_clk_en),
        .sess_sel   (sess_sel),
        .test_mode  (test_mode)
    );

    always #10 tck = ~tck;

    // {tms, shift, update, capture, tse, func, sclk1, sclk0}; starts in Run-Test/Idle
    localparam int NW = 29;
    localparam logic [7:0] WALK [0:NW-1] = '{
        8'b1_0000000, 8'b0_0010000, 8'b1_0000001, 8'b0_1001000, 8'b0_1001000,
        8'b1_0100100, 8'b1_0000100, 8'b1_0000100, 8'b0_0010000, 8'b1_0000001,
        8'b0_1001000, 8'b1_0100100, 8'b1_0000100, 8'b1_0000100, 8'b0_0010000,
        8'b0_0000010, 8'b0_0000010, 8'b1_0000001, 8'b0_1001000, 8'b1_0100100,
        8'b1_0000100, 8'b0_0000000, 8'b1_0000000, 8'b0_0010000, 8'b1_0000001,
        8'b0_1001000, 8'b1_0100100, 8'b1_0000100, 8'b0_0000000
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
    endtask

    function automatic logic [6:0] outs();
        return {wr_shift, wr_update, wr_capture, tse, func_clk_en, scan_clk_en};
    endfunction

    // from Run-Test/Idle, load an instruction LSB first, back in Run-Test/Idle
    task automatic load_ir(input logic [3:0] code);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            check("R11 ir capture bit", tdo, (i == 0) ? 1 : 0);
            tick(i == 3, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // from Run-Test/Idle, shift a session value, return captured bits
    task automatic shift_sess(input logic [2:0] val, output logic [2:0] got, input logic [2:0] old);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            got[i] = tdo;
            tick(i == 2, val[i]);
        end
        check("R8 sess_sel held before update", sess_sel, old);
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] got;
        @(negedge tck); @(negedge tck);
        // R1 reset state
        check("R1 outputs in reset", {outs(), tdo}, 8'h00);
        check("R1 sess_sel in reset", sess_sel, 0);
        check("R10 test_mode low in reset", test_mode, 0);
        trst_n = 1'b1;
        tick(1, 0);
        check("R10 test_mode after release", test_mode, 1);
        tick(0, 0);

        // R12: session instruction, strobes stay quiet
        load_ir(4'b0010);
        tick(1, 0); tick(0, 0);
        check("R12 no capture under session", outs(), 0);
        tick(1, 0);
        check("R12 no scan pulse under session", outs(), 0);
        tick(0, 0);
        check("R12 no shift/tse under session", outs(), 0);
        tick(1, 0); tick(1, 0); tick(0, 0);

        // R8 session register
        shift_sess(3'd5, got, 3'd0);
        check("R8 capture of old value", got, 0);
        check("R8 sess_sel updated", sess_sel, 5);
        shift_sess(3'd3, got, 3'd5);
        check("R8 readback of current value", got, 5);
        check("R8 sess_sel second update", sess_sel, 3);

        // R9 bypass under unknown code
        load_ir(4'b1010);
        tick(1, 0); tick(0, 0); tick(0, 0);
        check("R9 bypass captures 0", tdo, 0);
        tick(0, 1);
        check("R9 bypass delay 1", tdo, 1);
        tick(0, 0);
        check("R9 bypass delay 0", tdo, 0);
        tick(0, 1);
        check("R9 bypass delay 1b", tdo, 1);
        tick(1, 0); tick(1, 0); tick(0, 0);
        check("R9 sess_sel untouched", sess_sel, 3);

        // R3..R7 wrapper vector loop table
        load_ir(4'b0011);
        for (int i = 0; i < NW; i++) begin
            tick(WALK[i][7], 0);
            check($sformatf("R3 R4 R5 R6 R7 walk step %0d", i), outs(), WALK[i][6:0]);
        end

        // R2: four tms-high edges keep state, fifth resets
        tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
        check("R3 in pause before reset run", outs(), 7'b1001000);
        tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
        check("R2 four ones keep sess_sel", sess_sel, 3);
        tick(1, 0); tick(1, 0);
        check("R2 five ones clear sess_sel", sess_sel, 0);
        tick(0, 0); tick(1, 0); tick(0, 0);
        check("R2 instruction back to bypass", outs(), 0);
        tick(1, 0); tick(1, 0); tick(0, 0);

        // R1 asynchronous reset mid-run
        shift_sess(3'd6, got, 3'd0);
        check("R8 load before async reset", sess_sel, 0);
        load_ir(4'b0010);
        shift_sess(3'd6, got, 3'd0);
        check("R8 load six", sess_sel, 6);
        #3 trst_n = 1'b0;
        #1;
        check("R1 async clear of sess_sel", sess_sel, 0);
        check("R10 test_mode cleared", test_mode, 0);
        @(negedge tck);
        trst_n = 1'b1;
        tick(1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule